// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is a slave serial port that lets a host controller read and write a bank of thirty-two 8-bit configuration registers over one bidirectional data line. The host lowers an active-low select, clocks in an 8-bit command and then moves between one and four data bytes. The command carries the transfer direction, the byte count and the starting register address. The register contents leave the block on a flat bus that feeds the function they configure.

Incoming bits are sampled on the rising serial clock edge. Outgoing bits change on the falling edge. A register-held flag sets the bit order, most significant or least significant first, for both the command and the data. In a multibyte transfer the register address steps after every byte, and the direction of the step follows the bit order. Each written byte lands in its register the moment its final bit arrives. A separate abort pulse, or a select that rises early, drops any partly shifted byte and returns the port to the start of a command.

Top module: `spi3w_regport`

## Requirements
- R1: Each transfer starts with an 8-bit command taken on the first eight rising `sclk_i` edges after `cs_n_i` falls. Command bit 7 is the direction (1 = read, 0 = write), bits 6:5 hold the byte count minus one, and bits 4:0 hold the first register address.
- R2: Exactly count data bytes are moved. Once the last byte is done, further clocks with `cs_n_i` low change no register and do not drive the line, until `cs_n_i` rises.
- R3: After each data byte the address steps by one, modulo 32. It counts down when the order flag is clear and up when the flag is set.
- R4: Bit 6 of register 0 is the order flag: 1 means least-significant bit first, 0 means most-significant bit first. The flag applies to command bytes and data bytes alike.
- R5: A written register takes the new byte on the rising edge that samples the byte's last bit. Before that edge the register keeps its old value.
- R6: On a read, the first data bit appears on the falling edge after the last command bit. Each following bit changes on a falling edge. The register value is presented in the order set by R4.
- R7: `sdio_oe_o` is high only during the data phase of a read while `cs_n_i` is low. It is low during commands, during writes, after the last byte and while `cs_n_i` is high.
- R8: A high pulse on `abort_i` returns the port to the start of a command, even while `cs_n_i` stays low. A partly shifted byte is not written, and bytes completed earlier keep their values.
- R9: If `cs_n_i` rises mid-transfer, the completed bytes stay written, the partial byte is dropped, and the next select begins a new command.
- R10: After `rst_n_i` is asserted, every register reads zero and `sdio_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock from the host |
| rst_n_i | input | 1 | Asynchronous active-low reset, released on `sclk_i` |
| cs_n_i | input | 1 | Active-low select framing one transfer |
| abort_i | input | 1 | Active-high pulse that restarts the command phase |
| sdio_i | input | 1 | Data line as seen by the port |
| sdio_o | output | 1 | Value driven onto the data line during reads |
| sdio_oe_o | output | 1 | Enable for the data line's tristate driver |
| cfg_o | output | 256 | All registers; register n occupies bits n*8+7 down to n*8 |

## Verification
A wrong bit counter or a misdecoded command shows up on the first read-back as a byte rotated or taken from the wrong address. The commit check catches it one clock after the last bit of the affected byte. Address-stepping faults appear on the second byte of a multibyte transfer, and the tests at the bank edges catch wrap errors. Faults in the abort or select-release handling appear as a register that changes when it should not. The bench compares the whole register bus against its model right after the interrupting edge.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;
endpackage

// File: rtl/spi3w_shifter.sv
// Serial-in shift register; nxt is the value including the bit on sdio now.
module spi3w_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         en,
  input  logic         lsb_first,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;

  always_comb begin
    if (lsb_first) nxt = {din, q[W-1:1]};
    else           nxt = {q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  q <= '0;
    else if (en)  q <= nxt;
  end
endmodule

// File: rtl/spi3w_seq.sv
// Phase sequencer: command decode, byte counting and address stepping.
module spi3w_seq
  import spi3w_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 2
) (
  input  logic                       sclk,
  input  logic                       arst_n,
  input  logic                       lsb_first,
  input  logic [DATA_W-1:0]          sh_nxt,
  output phase_e                     phase,
  output logic                       rd_mode,
  output logic [$clog2(DATA_W)-1:0]  bit_idx,
  output logic                       shift_en,
  output logic                       wr_en,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       load_tx,
  output logic [ADDR_W-1:0]          tx_addr
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  phase_e              phase_q, phase_d;
  logic                rw_q, rw_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [CNT_W-1:0]    left_q, left_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   addr_step;
  logic                cmd_rw;
  logic [CNT_W-1:0]    cmd_cnt;
  logic [ADDR_W-1:0]   cmd_addr;

  assign cmd_rw    = sh_nxt[DATA_W-1];
  assign cmd_cnt   = sh_nxt[DATA_W-2 -: CNT_W];
  assign cmd_addr  = sh_nxt[ADDR_W-1:0];
  assign addr_step = lsb_first ? addr_q + 1'b1 : addr_q - 1'b1;

  always_comb begin
    phase_d = phase_q;
    rw_d    = rw_q;
    bit_d   = bit_q;
    left_d  = left_q;
    addr_d  = addr_q;
    wr_en   = 1'b0;
    load_tx = 1'b0;
    tx_addr = addr_q;
    case (phase_q)
      PH_INSTR: begin
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          bit_d   = '0;
          phase_d = PH_DATA;
          rw_d    = cmd_rw;
          left_d  = cmd_cnt;
          addr_d  = cmd_addr;
          load_tx = 1'b1;
          tx_addr = cmd_addr;
        end
      end
      PH_DATA: begin
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          bit_d = '0;
          wr_en = ~rw_q;
          if (left_q == '0) begin
            phase_d = PH_DONE;
          end else begin
            left_d  = left_q - 1'b1;
            addr_d  = addr_step;
            load_tx = rw_q;
            tx_addr = addr_step;
          end
        end
      end
      default: begin
        phase_d = PH_DONE;
      end
    endcase
  end

  always_ff @(posedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_INSTR;
      rw_q    <= 1'b0;
      bit_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      rw_q    <= rw_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
    end
  end

  assign phase    = phase_q;
  assign rd_mode  = rw_q;
  assign bit_idx  = bit_q;
  assign shift_en = (phase_q != PH_DONE);
  assign wr_addr  = addr_q;
  assign wr_data  = sh_nxt;
endmodule

// File: rtl/spi3w_regbank.sv
// Register bank with per-register write decode and a flat view of all bytes.
module spi3w_regbank #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int ORDER_REG = 0,
  parameter int ORDER_BIT = 6
) (
  input  logic                              clk,
  input  logic                              arst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 waddr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [ADDR_W-1:0]                 raddr,
  output logic [DATA_W-1:0]                 rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     cfg,
  output logic                              lsb_first
);
  localparam int NREGS = 1 << ADDR_W;

  for (genvar g = 0; g < NREGS; g++) begin : gen_reg
    logic [DATA_W-1:0] r_q;
    logic              hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  r_q <= '0;
      else if (hit) r_q <= wdata;
    end
    assign cfg[g*DATA_W +: DATA_W] = r_q;
  end

  assign rdata     = cfg[raddr*DATA_W +: DATA_W];
  assign lsb_first = cfg[ORDER_REG*DATA_W + ORDER_BIT];
endmodule

// File: rtl/spi3w_txdrv.sv
// Read path: byte loaded on the rising edge, bits and enable launched on falling.
module spi3w_txdrv #(
  parameter int DATA_W = 8
) (
  input  logic                       sclk,
  input  logic                       arst_n,
  input  logic                       load,
  input  logic [DATA_W-1:0]          load_data,
  input  logic                       lsb_first,
  input  logic [$clog2(DATA_W)-1:0]  bit_idx,
  input  logic                       drive_en,
  output logic                       sdo,
  output logic                       oe
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q;
  logic [BIT_W-1:0]  sel;
  logic              sdo_q, oe_q;

  always_ff @(posedge sclk or negedge arst_n) begin
    if (!arst_n)    tx_q <= '0;
    else if (load)  tx_q <= load_data;
  end

  assign sel = lsb_first ? bit_idx : BIT_W'(DATA_W - 1) - bit_idx;

  always_ff @(negedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sdo_q <= tx_q[sel];
      oe_q  <= drive_en;
    end
  end

  assign sdo = sdo_q;
  assign oe  = oe_q;
endmodule

// File: rtl/spi3w_regport.sv
module spi3w_regport
  import spi3w_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 2,
  parameter int ORDER_REG = 0,
  parameter int ORDER_BIT = 6
) (
  input  logic                            sclk_i,
  input  logic                            rst_n_i,
  input  logic                            cs_n_i,
  input  logic                            abort_i,
  input  logic                            sdio_i,
  output logic                            sdio_o,
  output logic                            sdio_oe_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   cfg_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [1:0]         rst_sync_q;
  logic               bank_rst_n;
  logic               seq_rst_n;
  logic               lsb_first;
  logic [DATA_W-1:0]  sh_nxt;
  phase_e             phase;
  logic               rd_mode;
  logic [BIT_W-1:0]   bit_idx;
  logic               shift_en;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic               load_tx;
  logic [ADDR_W-1:0]  tx_addr;
  logic [DATA_W-1:0]  tx_data;
  logic               drive_en;

  always_ff @(posedge sclk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign bank_rst_n = rst_sync_q[1];
  assign seq_rst_n  = bank_rst_n & ~cs_n_i & ~abort_i;

  spi3w_shifter #(.W(DATA_W)) u_shift (
    .clk       (sclk_i),
    .arst_n    (seq_rst_n),
    .en        (shift_en),
    .lsb_first (lsb_first),
    .din       (sdio_i),
    .nxt       (sh_nxt)
  );

  spi3w_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .sclk      (sclk_i),
    .arst_n    (seq_rst_n),
    .lsb_first (lsb_first),
    .sh_nxt    (sh_nxt),
    .phase     (phase),
    .rd_mode   (rd_mode),
    .bit_idx   (bit_idx),
    .shift_en  (shift_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .load_tx   (load_tx),
    .tx_addr   (tx_addr)
  );

  spi3w_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .ORDER_REG(ORDER_REG), .ORDER_BIT(ORDER_BIT)) u_bank (
    .clk       (sclk_i),
    .arst_n    (bank_rst_n),
    .we        (wr_en),
    .waddr     (wr_addr),
    .wdata     (wr_data),
    .raddr     (tx_addr),
    .rdata     (tx_data),
    .cfg       (cfg_o),
    .lsb_first (lsb_first)
  );

  assign drive_en = (phase == PH_DATA) && rd_mode;

  spi3w_txdrv #(.DATA_W(DATA_W)) u_tx (
    .sclk      (sclk_i),
    .arst_n    (seq_rst_n),
    .load      (load_tx),
    .load_data (tx_data),
    .lsb_first (lsb_first),
    .bit_idx   (bit_idx),
    .drive_en  (drive_en),
    .sdo       (sdio_o),
    .oe        (sdio_oe_o)
  );
endmodule

// File: rtl/spi3w_regport_chk.sv
module spi3w_regport_chk
  import spi3w_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic                            sclk,
  input logic                            rst_n,
  input logic                            cs_n,
  input logic                            abort,
  input logic                            oe,
  input phase_e                          phase,
  input logic                            rd_mode,
  input logic                            wr_en,
  input logic [ADDR_W-1:0]               wr_addr,
  input logic [DATA_W-1:0]               wr_data,
  input logic [(1<<ADDR_W)*DATA_W-1:0]   cfg
);
  logic              c_we;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic [DATA_W-1:0] c_sel;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      c_we   <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
    end else begin
      c_we   <= wr_en;
      c_addr <= wr_addr;
      c_data <= wr_data;
    end
  end
  assign c_sel = cfg[c_addr*DATA_W +: DATA_W];

  // R7
  oe_needs_select_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    oe |-> !cs_n);

  // R7
  oe_only_read_data_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    oe |-> (phase == PH_DATA && rd_mode));

  // R5
  byte_commit_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    c_we |-> (c_sel == c_data));

  // R2
  done_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (phase == PH_DONE) |-> (!oe && !wr_en));

  // R8
  abort_restart_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    abort |-> (phase == PH_INSTR && !wr_en && !oe));
endmodule

bind spi3w_regport spi3w_regport_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .sclk    (sclk_i),
  .rst_n   (rst_n_i),
  .cs_n    (cs_n_i),
  .abort   (abort_i),
  .oe      (sdio_oe_o),
  .phase   (phase),
  .rd_mode (rd_mode),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .cfg     (cfg_o)
);

// File: tb/spi3w_regport_tb.sv
module spi3w_regport_tb;
  logic         sclk = 1'b0;
  logic         rst_n, cs_n, abort, sdi;
  logic         sdo, oe;
  logic [255:0] cfg;
  int           vectors = 0;
  int           errs = 0;
  logic [7:0]   mdl [32];

  always #5 sclk = ~sclk;

  spi3w_regport u_dut (
    .sclk_i    (sclk),
    .rst_n_i   (rst_n),
    .cs_n_i    (cs_n),
    .abort_i   (abort),
    .sdio_i    (sdi),
    .sdio_o    (sdo),
    .sdio_oe_o (oe),
    .cfg_o     (cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mdl_flat();
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[i*8 +: 8] = mdl[i];
    return r;
  endfunction

  function automatic bit lsbf();
    return mdl[0][6];
  endfunction

  task automatic put_byte(input logic [7:0] b, input bit lsb);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk);
      sdi = lsb ? b[i] : b[7-i];
    end
  endtask

  task automatic begin_cycle();
    @(posedge sclk); #1;
    cs_n = 1'b0;
  endtask

  task automatic end_cycle();
    @(negedge sclk);
    cs_n = 1'b1;
    sdi  = 1'b0;
    @(negedge sclk);
  endtask

  task automatic send_cmd(input bit rd, input int n, input logic [4:0] a);
    logic [1:0] c;
    c = 2'(n - 1);
    put_byte({rd, c, a}, lsbf());
  endtask

  // Data bytes: d[7:0] first, d[15:8] second, and so on.
  task automatic wr_body(input logic [4:0] a0, input int n, input logic [31:0] d,
                         input string req);
    logic [4:0] a;
    bit         lsb;
    a = a0;
    for (int k = 0; k < n; k++) begin
      lsb = lsbf();
      put_byte(d[k*8 +: 8], lsb);
      chk(cfg[a*8 +: 8] == mdl[a], {"R5 before last edge ", req},
          256'(cfg[a*8 +: 8]), 256'(mdl[a]));
      @(posedge sclk); #1;
      mdl[a] = d[k*8 +: 8];
      chk(cfg[a*8 +: 8] == mdl[a], {"R5 commit ", req},
          256'(cfg[a*8 +: 8]), 256'(mdl[a]));
      a = lsb ? a + 5'd1 : a - 5'd1;
    end
  endtask

  task automatic rd_body(input logic [4:0] a0, input int n, input string req);
    logic [4:0] a;
    logic [7:0] b;
    bit         lsb;
    a = a0;
    for (int k = 0; k < n; k++) begin
      lsb = lsbf();
      for (int i = 0; i < 8; i++) begin
        @(negedge sclk); #3;
        if (i == 0) chk(oe == 1'b1, "R7 enable in read data", 256'(oe), 256'(1));
        if (lsb) b[i] = sdo;
        else     b[7-i] = sdo;
      end
      chk(b == mdl[a], {"R6 read byte ", req}, 256'(b), 256'(mdl[a]));
      a = lsb ? a + 5'd1 : a - 5'd1;
    end
    @(negedge sclk); #3;
    chk(oe == 1'b0, "R2 R7 no drive after count", 256'(oe), 256'(0));
  endtask

  task automatic t_reset();
    #1;
    chk(cfg == '0, "R10 regs zero in reset", cfg, '0);
    chk(oe == 1'b0, "R10 enable low in reset", 256'(oe), 256'(0));
    rst_n = 1'b1;
    repeat (4) @(posedge sclk);
    #1;
    chk(oe == 1'b0, "R7 idle enable low", 256'(oe), 256'(0));
  endtask

  task automatic t_single();
    begin_cycle(); send_cmd(1'b0, 1, 5'd5); wr_body(5'd5, 1, 32'h3C, "R1 single"); end_cycle();
    begin_cycle(); send_cmd(1'b1, 1, 5'd5); rd_body(5'd5, 1, "R1 single"); end_cycle();
  endtask

  task automatic t_multi_msb();
    begin_cycle(); send_cmd(1'b0, 4, 5'd10);
    wr_body(5'd10, 4, 32'h96_E1_2B_F0, "R3 descending");
    end_cycle();
    chk(cfg == mdl_flat(), "R3 descending bank", cfg, mdl_flat());
    begin_cycle(); send_cmd(1'b1, 4, 5'd10); rd_body(5'd10, 4, "R3 descending"); end_cycle();
  endtask

  task automatic t_wrap_msb();
    begin_cycle(); send_cmd(1'b0, 3, 5'd1);
    wr_body(5'd1, 3, 32'h5F_00_A1, "R3 wrap down");
    end_cycle();
    chk(cfg == mdl_flat(), "R3 wrap down bank", cfg, mdl_flat());
    begin_cycle(); send_cmd(1'b1, 3, 5'd1); rd_body(5'd1, 3, "R3 wrap down"); end_cycle();
  endtask

  task automatic t_count();
    begin_cycle(); send_cmd(1'b0, 1, 5'd20);
    wr_body(5'd20, 1, 32'h77, "R2 single");
    put_byte(8'hFF, lsbf());
    put_byte(8'hC6, lsbf());
    chk(cfg == mdl_flat(), "R2 extra clocks ignored", cfg, mdl_flat());
    end_cycle();
    begin_cycle(); send_cmd(1'b1, 2, 5'd11); rd_body(5'd11, 2, "R2 two bytes"); end_cycle();
  endtask

  task automatic t_lsb();
    begin_cycle(); send_cmd(1'b0, 1, 5'd0); wr_body(5'd0, 1, 32'h40, "R4 set order"); end_cycle();
    begin_cycle(); send_cmd(1'b0, 3, 5'd30);
    wr_body(5'd30, 3, 32'h40_34_12, "R4 R3 ascending wrap");
    end_cycle();
    chk(cfg == mdl_flat(), "R4 ascending bank", cfg, mdl_flat());
    begin_cycle(); send_cmd(1'b1, 3, 5'd30); rd_body(5'd30, 3, "R4 lsb first"); end_cycle();
    begin_cycle(); send_cmd(1'b1, 1, 5'd5); rd_body(5'd5, 1, "R4 lsb first single"); end_cycle();
    begin_cycle(); send_cmd(1'b0, 1, 5'd0); wr_body(5'd0, 1, 32'h00, "R4 restore order"); end_cycle();
  endtask

  task automatic t_abort();
    begin_cycle(); send_cmd(1'b0, 2, 5'd12);
    wr_body(5'd12, 1, 32'hC3, "R8 first byte");
    for (int i = 0; i < 4; i++) begin
      @(negedge sclk); sdi = 1'b1;
    end
    @(negedge sclk); abort = 1'b1;
    @(posedge sclk); #1; abort = 1'b0;
    chk(cfg == mdl_flat(), "R8 partial byte dropped", cfg, mdl_flat());
    send_cmd(1'b1, 2, 5'd12);
    rd_body(5'd12, 2, "R8 restart under select");
    end_cycle();
  endtask

  task automatic t_cs_early();
    begin_cycle(); send_cmd(1'b0, 3, 5'd25);
    wr_body(5'd25, 1, 32'hE7, "R9 first byte");
    for (int i = 0; i < 3; i++) begin
      @(negedge sclk); sdi = 1'b1;
    end
    @(negedge sclk); cs_n = 1'b1; sdi = 1'b0;
    #3;
    chk(cfg == mdl_flat(), "R9 partial byte dropped", cfg, mdl_flat());
    chk(oe == 1'b0, "R7 enable low with select high", 256'(oe), 256'(0));
    @(negedge sclk);
    begin_cycle(); send_cmd(1'b1, 2, 5'd25); rd_body(5'd25, 2, "R9 new cycle"); end_cycle();
  endtask

  task automatic t_reset_again();
    @(negedge sclk); rst_n = 1'b0;
    #1;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    chk(cfg == '0, "R10 reset clears bank", cfg, '0);
    @(negedge sclk); rst_n = 1'b1;
    repeat (3) @(posedge sclk);
  endtask

  initial begin
    repeat (200000) @(posedge sclk);
    errs++;
    vectors++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n  = 1'b1;
    abort = 1'b0;
    sdi   = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    t_reset();
    t_single();
    t_multi_msb();
    t_wrap_msb();
    t_count();
    t_lsb();
    t_abort();
    t_cs_early();
    t_reset_again();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule